// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block lets a host reach a downstream configuration space through a pair of host registers: an address register that names the target location, and a data window through which byte, halfword and word reads and writes pass downstream. Each window access that is let through becomes one downstream request. The request carries an address built from the held address and the window offset, a size code and write data. A read request then waits for the downstream read data.

The top bit of the held address acts as a gate. While it is clear, window writes are dropped and window reads answer at once with all-ones at the access width, and nothing is sent downstream. A compile-time option swaps byte order on halfword and word data in both directions, for use behind a big-endian host.

The host side takes one access at a time. An access is accepted when `host_req` is high while `host_ready` is high. Completion is a one-cycle `host_rsp_valid` pulse, with the read result on `host_rdata`.

Top module: `cfg_port_bridge`

## Requirements
- R1: The address register sits at host offset 0 (host_ofs[2]=0). A write stores all 32 bits of host_wdata regardless of host_size. A read returns the stored value. The register resets to 0.
- R2: A window access (host_ofs[2]=1) produces a downstream request (dn_valid high) only when bit 31 of the address register is 1. dn_valid is never high at any other time.
- R3: A window write with bit 31 clear sends nothing downstream. host_rsp_valid pulses in the cycle after acceptance.
- R4: A window read with bit 31 clear answers in the cycle after acceptance. host_rdata is 32'h000000FF for a byte (host_size=0), 32'h0000FFFF for a halfword (host_size=1) and 32'hFFFFFFFF for a word (host_size=2).
- R5: For byte and halfword accesses, dn_addr is the address register ORed with host_ofs[1:0].
- R6: For a word write, dn_addr equals the address register and host_ofs[1:0] is ignored. For a word read, dn_addr is the address register ORed with host_ofs[1:0].
- R7: dn_size is 3'b001 for a byte, 3'b010 for a halfword and 3'b100 for a word.
- R8: A downstream request holds dn_valid, dn_addr, dn_size, dn_we and dn_wdata steady until dn_ready is seen. A forwarded write completes in the cycle after that handshake. A forwarded read completes in the cycle after dn_rvalid.
- R9: Sub-word write data goes out on the low lanes of dn_wdata with the upper bits zero. Sub-word read data is taken from the low lanes of dn_rdata and zero-extended on host_rdata.
- R10: With BIG_ENDIAN=1, the two bytes of a halfword and the four bytes of a word are reversed on both dn_wdata and host_rdata. Byte data is never reversed. With BIG_ENDIAN=0, no lane is reversed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access request |
| host_ready | output | 1 | Bridge idle, able to accept an access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_ofs | input | 3 | Bit 2 selects the window (1) or the address register (0); bits 1:0 are the window byte offset |
| host_size | input | 2 | 0 byte, 1 halfword, 2 word |
| host_wdata | input | 32 | Host write data |
| host_rsp_valid | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read result, valid with host_rsp_valid |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream request accepted |
| dn_we | output | 1 | Downstream write flag |
| dn_addr | output | 32 | Composed configuration address |
| dn_size | output | 3 | Size code 1, 2 or 4 bytes |
| dn_wdata | output | 32 | Downstream write data |
| dn_rvalid | input | 1 | Downstream read data valid |
| dn_rdata | input | 32 | Downstream read data |

## Verification
The assertions assume the host raises host_req only while host_ready is high and uses host_size values 0 to 2. They also assume downstream raises dn_rvalid only for a read whose request has been handshaken. The bench drives one access at a time and waits for each completion pulse. It gives dn_ready and dn_rvalid only at those points, after a random delay of zero to two cycles.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } bridge_st_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  // Keep the lanes covered by the access width, then reverse their byte
  // order when the big-endian option is on. Symmetric in both directions.
  function automatic logic [31:0] lane_fit(input logic [31:0] d,
                                           input logic [1:0]  sz,
                                           input logic        be);
    logic [31:0] m;
    logic [31:0] r;
    int unsigned nb;
    if (sz == SZ_BYTE) begin
      m  = {24'd0, d[7:0]};
      nb = 1;
    end else if (sz == SZ_HALF) begin
      m  = {16'd0, d[15:0]};
      nb = 2;
    end else begin
      m  = d;
      nb = 4;
    end
    r = m;
    if (be) begin
      r = '0;
      for (int unsigned k = 0; k < 4; k++) begin
        if (k < nb) r[8*k +: 8] = m[8*(nb-1-k) +: 8];
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/cfgb_addr_reg.sv
module cfgb_addr_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (wr_en) q_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/cfgb_compose.sv
module cfgb_compose #(
  parameter int unsigned AW         = 32,
  parameter bit          BIG_ENDIAN = 1'b0
) (
  input  logic [AW-1:0] cfg_addr,
  input  logic [1:0]    win_ofs,
  input  logic [1:0]    acc_size,
  input  logic          acc_we,
  input  logic [31:0]   acc_wdata,
  output logic [AW-1:0] out_addr,
  output logic [2:0]    out_size,
  output logic [31:0]   out_wdata
);
  import cfgb_pkg::*;

  logic is_word;
  assign is_word = !(acc_size == SZ_BYTE || acc_size == SZ_HALF);

  always_comb begin
    out_addr = cfg_addr;
    if (!(is_word && acc_we)) out_addr[1:0] = cfg_addr[1:0] | win_ofs;
    unique case (acc_size)
      SZ_BYTE: out_size = 3'b001;
      SZ_HALF: out_size = 3'b010;
      default: out_size = 3'b100;
    endcase
    out_wdata = lane_fit(acc_wdata, acc_size, BIG_ENDIAN);
  end
endmodule

// File: rtl/cfgb_rdpath.sv
module cfgb_rdpath #(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic        use_raw,
  input  logic [1:0]  acc_size,
  input  logic [31:0] raw,
  output logic [31:0] result
);
  import cfgb_pkg::*;

  always_comb begin
    if (use_raw)                    result = lane_fit(raw, acc_size, BIG_ENDIAN);
    else if (acc_size == SZ_BYTE)   result = 32'h0000_00FF;
    else if (acc_size == SZ_HALF)   result = 32'h0000_FFFF;
    else                            result = 32'hFFFF_FFFF;
  end
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge #(
  parameter int unsigned ADDR_W     = 32,
  parameter bit          BIG_ENDIAN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  output logic              host_ready,
  input  logic              host_we,
  input  logic [2:0]        host_ofs,
  input  logic [1:0]        host_size,
  input  logic [31:0]       host_wdata,
  output logic              host_rsp_valid,
  output logic [31:0]       host_rdata,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic              dn_we,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [2:0]        dn_size,
  output logic [31:0]       dn_wdata,
  input  logic              dn_rvalid,
  input  logic [31:0]       dn_rdata
);
  import cfgb_pkg::*;

  localparam int unsigned EN_BIT = ADDR_W - 1;

  bridge_st_e        st_q, st_d;
  logic [ADDR_W-1:0] cfg_q;
  logic [ADDR_W-1:0] cmp_addr;
  logic [2:0]        cmp_size;
  logic [31:0]       cmp_wdata;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        size_q;
  logic [31:0]       wdata_q;
  logic              we_q;
  logic [1:0]        hsz_q;
  logic [31:0]       rdata_q, rdata_d;
  logic [31:0]       rd_fmt;
  logic              accept, is_win, win_on, load_req, cfg_wr, rdata_en;

  assign accept   = host_req && (st_q == ST_IDLE);
  assign is_win   = host_ofs[2];
  assign win_on   = cfg_q[EN_BIT];
  assign load_req = accept && is_win && win_on;
  assign cfg_wr   = accept && !is_win && host_we;

  cfgb_addr_reg #(.W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_data (host_wdata[ADDR_W-1:0]),
    .q       (cfg_q)
  );

  cfgb_compose #(.AW(ADDR_W), .BIG_ENDIAN(BIG_ENDIAN)) u_cmp (
    .cfg_addr  (cfg_q),
    .win_ofs   (host_ofs[1:0]),
    .acc_size  (host_size),
    .acc_we    (host_we),
    .acc_wdata (host_wdata),
    .out_addr  (cmp_addr),
    .out_size  (cmp_size),
    .out_wdata (cmp_wdata)
  );

  cfgb_rdpath #(.BIG_ENDIAN(BIG_ENDIAN)) u_rd (
    .use_raw  (st_q == ST_WAIT),
    .acc_size ((st_q == ST_WAIT) ? hsz_q : host_size),
    .raw      (dn_rdata),
    .result   (rd_fmt)
  );

  // next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = load_req ? ST_REQ : ST_DONE;
      ST_REQ:  if (dn_ready) st_d = we_q ? ST_DONE : ST_WAIT;
      ST_WAIT: if (dn_rvalid) st_d = ST_DONE;
      default: st_d = ST_IDLE;
    endcase
  end

  // read result
  always_comb begin
    rdata_en = 1'b0;
    rdata_d  = rdata_q;
    if (accept) begin
      rdata_en = 1'b1;
      rdata_d  = host_we ? 32'd0 : (is_win ? rd_fmt : 32'(cfg_q));
    end else if (st_q == ST_WAIT && dn_rvalid) begin
      rdata_en = 1'b1;
      rdata_d  = rd_fmt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      size_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      hsz_q   <= '0;
    end else if (load_req) begin
      addr_q  <= cmp_addr;
      size_q  <= cmp_size;
      wdata_q <= host_we ? cmp_wdata : 32'd0;
      we_q    <= host_we;
      hsz_q   <= host_size;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  assign host_ready     = (st_q == ST_IDLE);
  assign host_rsp_valid = (st_q == ST_DONE);
  assign host_rdata     = rdata_q;
  assign dn_valid       = (st_q == ST_REQ);
  assign dn_we          = we_q;
  assign dn_addr        = addr_q;
  assign dn_size        = size_q;
  assign dn_wdata       = wdata_q;

  AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_valid) |-> $past(cfg_q[EN_BIT])) else $error("AST_REQ_NEEDS_EN"); // R2
  AST_OFF_WR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_ready && is_win && !win_on && host_we) |=> (host_rsp_valid && !dn_valid))
    else $error("AST_OFF_WR_DONE"); // R3
  AST_OFF_RD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_ready && is_win && !win_on && !host_we && host_size == 2'd0)
      |=> (host_rsp_valid && host_rdata == 32'h0000_00FF)) else $error("AST_OFF_RD_BYTE"); // R4
  AST_SIZE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> ($countones(dn_size) == 1)) else $error("AST_SIZE_CODE"); // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_wdata)
                                 && $stable(dn_size) && $stable(dn_we)))
    else $error("AST_REQ_HOLD"); // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_valid |=> !host_rsp_valid) else $error("AST_RSP_PULSE"); // R8

endmodule

// File: tb/cfg_port_bridge_tb_top.sv
module cfg_port_bridge_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic        h_req = 1'b0, h_we = 1'b0;
  logic [2:0]  h_ofs = '0;
  logic [1:0]  h_sz = '0;
  logic [31:0] h_wd = '0;
  logic        d_ready = 1'b0, d_rvalid = 1'b0;
  logic [31:0] d_rdata = '0;

  logic        h_rdy [2];
  logic        r_v   [2];
  logic [31:0] r_d   [2];
  logic        d_v   [2];
  logic        d_we  [2];
  logic [31:0] d_a   [2];
  logic [2:0]  d_sz  [2];
  logic [31:0] d_wd  [2];

  cfg_port_bridge #(.ADDR_W(32), .BIG_ENDIAN(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(h_req), .host_ready(h_rdy[0]),
    .host_we(h_we), .host_ofs(h_ofs), .host_size(h_sz), .host_wdata(h_wd),
    .host_rsp_valid(r_v[0]), .host_rdata(r_d[0]), .dn_valid(d_v[0]),
    .dn_ready(d_ready), .dn_we(d_we[0]), .dn_addr(d_a[0]), .dn_size(d_sz[0]),
    .dn_wdata(d_wd[0]), .dn_rvalid(d_rvalid), .dn_rdata(d_rdata));

  cfg_port_bridge #(.ADDR_W(32), .BIG_ENDIAN(1'b1)) dut_be_i (
    .clk(clk), .rst_n(rst_n), .host_req(h_req), .host_ready(h_rdy[1]),
    .host_we(h_we), .host_ofs(h_ofs), .host_size(h_sz), .host_wdata(h_wd),
    .host_rsp_valid(r_v[1]), .host_rdata(r_d[1]), .dn_valid(d_v[1]),
    .dn_ready(d_ready), .dn_we(d_we[1]), .dn_addr(d_a[1]), .dn_size(d_sz[1]),
    .dn_wdata(d_wd[1]), .dn_rvalid(d_rvalid), .dn_rdata(d_rdata));

  int checks = 0;
  int bad = 0;
  logic [31:0] mdl_cfg = '0;
  logic [31:0] mdl_last_cfg [$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h @%0t", req, act, exp, $time);
    end
  endtask

  // reference data lane model (R9, R10)
  function automatic logic [31:0] exp_lane(input logic [31:0] d, input logic [1:0] sz,
                                           input bit be);
    case (sz)
      2'd0:    return {24'd0, d[7:0]};
      2'd1:    return be ? {16'd0, d[7:0], d[15:8]} : {16'd0, d[15:0]};
      default: return be ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
    endcase
  endfunction

  function automatic logic [31:0] exp_ones(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  // continuous check R2: no request while the model's gate bit is clear
  always @(negedge clk) begin
    if (rst_n && !mdl_cfg[31]) begin
      for (int i = 0; i < 2; i++) chk(d_v[i] == 1'b0, "R2 gate", 32'(d_v[i]), 32'd0);
    end
  end

  task automatic access(input bit we, input logic [2:0] ofs, input logic [1:0] sz,
                        input logic [31:0] wd, input logic [31:0] rd);
    bit fwd;
    logic [31:0] ea;
    logic [2:0]  es;
    h_req = 1'b1; h_we = we; h_ofs = ofs; h_sz = sz; h_wd = wd;
    fwd = ofs[2] && mdl_cfg[31];
    ea  = (we && sz == 2'd2) ? mdl_cfg : (mdl_cfg | {30'd0, ofs[1:0]});
    es  = (sz == 2'd0) ? 3'b001 : (sz == 2'd1) ? 3'b010 : 3'b100;
    @(posedge clk); @(negedge clk);
    h_req = 1'b0;
    if (!fwd) begin
      for (int i = 0; i < 2; i++) begin
        chk(r_v[i] && !d_v[i], ofs[2] ? (we ? "R3 done" : "R4 done") : "R1 done",
            32'(r_v[i]), 32'd1);
        if (!we) begin
          if (ofs[2]) chk(r_d[i] == exp_ones(sz), "R4 ones", r_d[i], exp_ones(sz));
          else        chk(r_d[i] == mdl_cfg, "R1 readback", r_d[i], mdl_cfg);
        end
      end
      if (!ofs[2] && we) mdl_cfg = wd;
      @(posedge clk); @(negedge clk);
    end else begin
      for (int i = 0; i < 2; i++) begin
        chk(d_v[i] == 1'b1, "R2 request", 32'(d_v[i]), 32'd1);
        chk(d_a[i] == ea, (sz == 2'd2) ? "R6 addr" : "R5 addr", d_a[i], ea);
        chk(d_sz[i] == es, "R7 size", 32'(d_sz[i]), 32'(es));
        chk(d_we[i] == we, "R8 we", 32'(d_we[i]), 32'(we));
        if (we) chk(d_wd[i] == exp_lane(wd, sz, i == 1), "R10 R9 wdata", d_wd[i],
                    exp_lane(wd, sz, i == 1));
      end
      repeat ($urandom_range(0, 2)) begin
        @(posedge clk); @(negedge clk);
        for (int i = 0; i < 2; i++)
          chk(d_v[i] && d_a[i] == ea && !r_v[i], "R8 hold", d_a[i], ea);
      end
      d_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      d_ready = 1'b0;
      if (we) begin
        for (int i = 0; i < 2; i++) chk(r_v[i] && !d_v[i], "R8 wr done", 32'(r_v[i]), 32'd1);
        @(posedge clk); @(negedge clk);
      end else begin
        repeat ($urandom_range(0, 2)) begin
          for (int i = 0; i < 2; i++) chk(!r_v[i] && !d_v[i], "R8 rd wait", 32'(r_v[i]), 32'd0);
          @(posedge clk); @(negedge clk);
        end
        d_rvalid = 1'b1; d_rdata = rd;
        @(posedge clk); @(negedge clk);
        d_rvalid = 1'b0; d_rdata = '0;
        for (int i = 0; i < 2; i++) begin
          chk(r_v[i] == 1'b1, "R8 rd done", 32'(r_v[i]), 32'd1);
          chk(r_d[i] == exp_lane(rd, sz, i == 1), "R10 R9 rdata", r_d[i],
              exp_lane(rd, sz, i == 1));
        end
        @(posedge clk); @(negedge clk);
      end
    end
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 2; i++)
      chk(h_rdy[i] && !r_v[i] && !d_v[i], "R1 reset idle", 32'(h_rdy[i]), 32'd1);
    access(1'b0, 3'd0, 2'd2, '0, '0);                 // R1 reset value
    for (int s = 0; s < 3; s++)
      for (int o = 0; o < 4; o++) begin
        access(1'b1, 3'(4 + o), 2'(s), 32'hA5A5_5A5A, '0); // R3
        access(1'b0, 3'(4 + o), 2'(s), '0, '0);            // R4
      end
    access(1'b1, 3'd0, 2'd0, 32'h1234_5678, '0);      // R1 full width despite size
    access(1'b0, 3'd0, 2'd2, '0, '0);
    access(1'b1, 3'd4, 2'd2, 32'hDEAD_BEEF, '0);      // still gated (R2)
    access(1'b1, 3'd0, 2'd2, 32'h8001_2340, '0);      // enable
    for (int o = 0; o < 4; o++) begin
      access(1'b1, 3'(4 + o), 2'd0, 32'hFFFF_FF00 | 32'(o + 8'h31), '0); // R5 R9
      access(1'b0, 3'(4 + o), 2'd0, '0, 32'hCAFE_F00D + 32'(o));         // R5 R9
    end
    access(1'b1, 3'd4, 2'd1, 32'h7777_ABCD, '0);      // R5 R10
    access(1'b1, 3'd6, 2'd1, 32'h1111_0102, '0);
    access(1'b0, 3'd6, 2'd1, '0, 32'h9988_7766);
    access(1'b1, 3'd7, 2'd2, 32'h0102_0304, '0);      // R6 word write ignores offset
    access(1'b0, 3'd4, 2'd2, '0, 32'hA1B2_C3D4);      // R10
    access(1'b0, 3'd5, 2'd2, '0, 32'h5566_7788);      // R6 word read ORs offset
    access(1'b1, 3'd0, 2'd2, 32'h0000_0F00, '0);      // disable again
    access(1'b0, 3'd5, 2'd1, '0, '0);                 // R4
    access(1'b0, 3'd0, 2'd2, '0, '0);                 // R1
    for (int n = 0; n < 20; n++) begin
      access(1'b1, 3'd0, 2'd2, {1'b1, 31'($urandom) & 31'h7FFF_FFFC}, '0);
      access(1'($urandom), 3'(4 + $urandom_range(0, 3)), 2'($urandom_range(0, 2)),
             $urandom, $urandom);
    end
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule